// File: doc/BRIEF.md
# CCD Vertical Field Sequencer

This block generates the six vertical transfer clocks of a CCD readout field from a pixel-rate clock and two single-cycle strobes: a line strobe and a field strobe. The waveforms come from a three-level configuration hierarchy. A pattern group holds one pixel-level waveform: a length, a rest level for each output, and two toggle points for each output. A sequence names one pattern group, a pixel position where that pattern starts within the line, and how many times it is replayed back to back. A field splits its lines into up to seven regions, and each region selects one sequence.

A mode table lists up to seven slots that give the order in which field definitions are played. The same field may occupy several slots. Each field strobe moves to the next slot. The index of the sequence in force is an output, so that the horizontal clamp and blanking logic can select its own pulse set for those lines. A one-cycle flag marks each completed field.

Configuration is written through a plain register write port. Every write is accepted in the cycle it is presented, so the port has no back-pressure. Writes land in a shadow copy, and all of them become active together at the next field strobe. A field never runs with settings that are only partly updated.

Top module: `vfield_seq`

## Requirements
- R1: While reset is asserted and afterwards, until configuration is committed and a pattern is reached, `vclk_o` is 0, `seq_idx_o` is 0 and `field_done_o` is 0.
- R2: Both strobes clear the pixel counter to 0, and it then counts one per clock. At pixel k, with sequence start S, pattern length L = len_m1+1 and repeat count N > 0, for S <= k < S+N*L let q = (k-S) mod L. Output bit j is rest[j] XOR (q >= togA[j]) XOR (q >= togB[j]). At every other pixel, output bit j is rest[j]. The value for pixel k appears on `vclk_o` one clock after the counter holds k.
- R3: With a repeat count of 0, `vclk_o` stays at the rest levels of the selected pattern for the whole line. The repeat counter never reaches the programmed count while a pattern is running.
- R4: A field strobe resets the line counter and the region index to 0. Each line strobe increments the line counter. If the new line number equals the boundary stored for the current region (regions 0 to 5), the region index advances by one in the same clock. `seq_idx_o` reports the sequence selected for the current region of the current field.
- R5: Field slots play in order 0, 1, ... up to count-1, then wrap to 0. The slot count comes from the mode table in force while the finished field played; a count of 0 acts as 1. The first field strobe after reset plays slot 0. One field may fill several slots.
- R6: `field_done_o` pulses for exactly one clock, directly after each field strobe except the first one after reset.
- R7: Writes change only the shadow copy. All of it becomes active on the clock of a field strobe. A write presented in the same clock as a field strobe takes effect at the following field strobe.
- R8: When both strobes fall in the same clock, the field strobe wins: the line counter, region index and pixel counter restart at 0, and the slot advances as for a lone field strobe.
- R9: A pattern, sequence or field index at or above the number of stored entries selects entry 0.

Address map (10 bits; the top two bits select the page):
- Page 0 holds pattern groups: address bits [7:4] give the group. Word 0 is len_m1, word 1 is the rest levels, words 2 to 7 are togA for outputs 0 to 5, and words 8 to 13 are togB for outputs 0 to 5.
- Page 1 holds sequences: address bits [7:2] give the sequence. Word 0 is the pattern index, word 1 is the start pixel, word 2 is the repeat count.
- Page 2 holds fields: address bits [7:4] give the field. Words 0 to 6 give the sequence for regions 0 to 6. Words 8 to 13 give the boundaries that end regions 0 to 5.
- Page 3 holds the mode table: word 0 is the slot count, and words 1 to 7 give the field index for slots 0 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_i | input | 1 | Line strobe, one clock wide |
| vd_i | input | 1 | Field strobe, one clock wide; also commits the configuration |
| cfg_wr_en | input | 1 | Register write enable |
| cfg_wr_addr | input | 10 | Register write address |
| cfg_wr_data | input | 16 | Register write data, right aligned |
| vclk_o | output | 6 | Vertical transfer clocks |
| seq_idx_o | output | 4 | Sequence in force on the current line |
| field_done_o | output | 1 | One-clock pulse after each completed field |

## Verification
Two functions can fall in the same clock. The first case is a configuration write that arrives on the field strobe: the bench places a write to a sequence start pixel on that strobe. It then checks every pixel of the next field against the old value, and every pixel of the field after it against the new value. The second case is the two strobes arriving together: the bench raises both at once. It judges that line 0, region 0, the slot advance and the done pulse all match a lone field strobe.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  localparam int NOUT   = 6;
  localparam int NPAT   = 10;
  localparam int NSEQ   = 10;
  localparam int NFLD   = 6;
  localparam int NREG   = 7;
  localparam int NSLOT  = 7;
  localparam int PH_W   = 8;
  localparam int PIX_W  = 12;
  localparam int REP_W  = 8;
  localparam int IDX_W  = 4;
  localparam int FLD_W  = 3;
  localparam int SLOT_W = 3;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 16;
  localparam int REG_W  = $clog2(NREG);

  typedef struct packed {
    logic [PH_W-1:0]            len_m1;
    logic [NOUT-1:0]            rest;
    logic [NOUT-1:0][PH_W-1:0]  tog_a;
    logic [NOUT-1:0][PH_W-1:0]  tog_b;
  } pat_cfg_t;

  typedef struct packed {
    logic [IDX_W-1:0] pat;
    logic [PIX_W-1:0] start;
    logic [REP_W-1:0] reps;
  } seq_cfg_t;

  typedef struct packed {
    logic [NREG-1:0][IDX_W-1:0]   rseq;
    logic [NREG-2:0][PIX_W-1:0]   bnd;
  } fld_cfg_t;

  typedef struct packed {
    logic [SLOT_W-1:0]             count;
    logic [NSLOT-1:0][FLD_W-1:0]   slot;
  } mode_cfg_t;
endpackage

// File: rtl/vfs_cfg_bank.sv
module vfs_cfg_bank
  import vfs_pkg::*;
#(
  parameter int N_PAT = NPAT,
  parameter int N_SEQ = NSEQ,
  parameter int N_FLD = NFLD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  input  logic [SLOT_W-1:0] slot,
  input  logic [REG_W-1:0]  region,
  output pat_cfg_t          cur_pat,
  output seq_cfg_t          cur_seq,
  output logic [IDX_W-1:0]  cur_seq_idx,
  output logic [PIX_W-1:0]  next_bnd,
  output logic [SLOT_W-1:0] slot_count
);
  logic [1:0] page;
  logic [3:0] k16;
  logic [1:0] k4;
  logic [3:0] ent16;
  logic [5:0] ent4;
  assign page  = wr_addr[9:8];
  assign k16   = wr_addr[3:0];
  assign k4    = wr_addr[1:0];
  assign ent16 = wr_addr[7:4];
  assign ent4  = wr_addr[7:2];

  pat_cfg_t  sh_pat [N_PAT];
  pat_cfg_t  ac_pat [N_PAT];
  seq_cfg_t  sh_seq [N_SEQ];
  seq_cfg_t  ac_seq [N_SEQ];
  fld_cfg_t  sh_fld [N_FLD];
  fld_cfg_t  ac_fld [N_FLD];
  mode_cfg_t sh_mode, ac_mode;

  for (genvar p = 0; p < N_PAT; p++) begin : g_pat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_pat[p] <= '0;
        ac_pat[p] <= '0;
      end else begin
        if (commit) ac_pat[p] <= sh_pat[p];
        if (wr_en && page == 2'd0 && ent16 == 4'(p)) begin
          if (k16 == 4'd0) sh_pat[p].len_m1 <= wr_data[PH_W-1:0];
          if (k16 == 4'd1) sh_pat[p].rest   <= wr_data[NOUT-1:0];
          for (int j = 0; j < NOUT; j++) begin
            if (k16 == 4'(j + 2))        sh_pat[p].tog_a[j] <= wr_data[PH_W-1:0];
            if (k16 == 4'(j + 2 + NOUT)) sh_pat[p].tog_b[j] <= wr_data[PH_W-1:0];
          end
        end
      end
    end
  end

  for (genvar s = 0; s < N_SEQ; s++) begin : g_seq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_seq[s] <= '0;
        ac_seq[s] <= '0;
      end else begin
        if (commit) ac_seq[s] <= sh_seq[s];
        if (wr_en && page == 2'd1 && ent4 == 6'(s)) begin
          if (k4 == 2'd0) sh_seq[s].pat   <= wr_data[IDX_W-1:0];
          if (k4 == 2'd1) sh_seq[s].start <= wr_data[PIX_W-1:0];
          if (k4 == 2'd2) sh_seq[s].reps  <= wr_data[REP_W-1:0];
        end
      end
    end
  end

  for (genvar f = 0; f < N_FLD; f++) begin : g_fld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_fld[f] <= '0;
        ac_fld[f] <= '0;
      end else begin
        if (commit) ac_fld[f] <= sh_fld[f];
        if (wr_en && page == 2'd2 && ent16 == 4'(f)) begin
          for (int j = 0; j < NREG; j++)
            if (k16 == 4'(j)) sh_fld[f].rseq[j] <= wr_data[IDX_W-1:0];
          for (int j = 0; j < NREG - 1; j++)
            if (k16 == 4'(j + 8)) sh_fld[f].bnd[j] <= wr_data[PIX_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_mode <= '0;
      ac_mode <= '0;
    end else begin
      if (commit) ac_mode <= sh_mode;
      if (wr_en && page == 2'd3 && ent16 == 4'd0) begin
        if (k16 == 4'd0) sh_mode.count <= wr_data[SLOT_W-1:0];
        for (int j = 0; j < NSLOT; j++)
          if (k16 == 4'(j + 1)) sh_mode.slot[j] <= wr_data[FLD_W-1:0];
      end
    end
  end

  // Lookup chain: slot -> field -> region sequence -> pattern group
  logic [FLD_W-1:0] fidx;
  logic [IDX_W-1:0] sidx;
  logic [IDX_W-1:0] pidx;
  fld_cfg_t         fsel;

  always_comb begin
    fidx = ac_mode.slot[slot];
    if (int'(fidx) >= N_FLD) fidx = '0;
    fsel = ac_fld[fidx];
    sidx = fsel.rseq[region];
    if (int'(sidx) >= N_SEQ) sidx = '0;
    cur_seq = ac_seq[sidx];
    pidx = cur_seq.pat;
    if (int'(pidx) >= N_PAT) pidx = '0;
    cur_pat = ac_pat[pidx];
    cur_seq_idx = sidx;
    next_bnd = '1;
    for (int j = 0; j < NREG - 1; j++)
      if (region == REG_W'(j)) next_bnd = fsel.bnd[j];
    slot_count = (ac_mode.count == '0) ? SLOT_W'(1) : ac_mode.count;
  end

  AST_MODE_HELD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(ac_mode)); // R7
  AST_SEQ0_HELD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(ac_seq[0])); // R7
endmodule

// File: rtl/vfs_line_tracker.sv
module vfs_line_tracker
  import vfs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hd,
  input  logic              vd,
  input  logic [PIX_W-1:0]  next_bnd,
  input  logic [SLOT_W-1:0] slot_count,
  output logic [PIX_W-1:0]  pix,
  output logic              line_start,
  output logic [REG_W-1:0]  region,
  output logic [SLOT_W-1:0] slot,
  output logic              field_done
);
  logic [PIX_W-1:0] line_q;
  logic [PIX_W-1:0] line_inc;
  logic             started;

  assign line_start = hd | vd;
  assign line_inc   = (&line_q) ? line_q : line_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix        <= '0;
      line_q     <= '0;
      region     <= '0;
      slot       <= '0;
      started    <= 1'b0;
      field_done <= 1'b0;
    end else if (vd) begin
      pix        <= '0;
      line_q     <= '0;
      region     <= '0;
      started    <= 1'b1;
      field_done <= started;
      if (!started || (slot + 1'b1) >= slot_count) slot <= '0;
      else                                          slot <= slot + 1'b1;
    end else begin
      field_done <= 1'b0;
      if (hd) begin
        pix    <= '0;
        line_q <= line_inc;
        if (region < REG_W'(NREG - 1) && line_inc == next_bnd) region <= region + 1'b1;
      end else if (!(&pix)) begin
        pix <= pix + 1'b1;
      end
    end
  end

  AST_DONE_FOLLOWS_VD: assert property (@(posedge clk) disable iff (!rst_n)
    field_done |-> $past(vd)); // R6
  AST_REGION_MOVES_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(region) |-> $past(hd || vd)); // R4
  AST_VD_RESTARTS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    vd |=> (line_q == '0 && region == '0 && pix == '0)); // R8
  AST_SLOT_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    slot < SLOT_W'(NSLOT)); // R5
endmodule

// File: rtl/vfs_pattern_walker.sv
module vfs_pattern_walker
  import vfs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [PIX_W-1:0] pix,
  input  pat_cfg_t         pat,
  input  seq_cfg_t         seq,
  output logic [NOUT-1:0]  vclk
);
  logic             run, done;
  logic [PH_W-1:0]  ph, cur_ph;
  logic [REP_W-1:0] rc, cur_rc;
  logic             in_pat, last_ph, last_rep;
  logic [NOUT-1:0]  lvl;

  assign in_pat   = !line_start && (run || (!done && seq.reps != '0 && pix == seq.start));
  assign cur_ph   = run ? ph : '0;
  assign cur_rc   = run ? rc : '0;
  assign last_ph  = (cur_ph == pat.len_m1);
  assign last_rep = ((cur_rc + 1'b1) == seq.reps);

  for (genvar j = 0; j < NOUT; j++) begin : g_lvl
    assign lvl[j] = pat.rest[j] ^ (cur_ph >= pat.tog_a[j]) ^ (cur_ph >= pat.tog_b[j]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      done <= 1'b0;
      ph   <= '0;
      rc   <= '0;
      vclk <= '0;
    end else begin
      vclk <= in_pat ? lvl : pat.rest;
      if (line_start) begin
        run  <= 1'b0;
        done <= 1'b0;
        ph   <= '0;
        rc   <= '0;
      end else if (in_pat) begin
        if (last_ph) begin
          ph <= '0;
          if (last_rep) begin
            run  <= 1'b0;
            done <= 1'b1;
            rc   <= '0;
          end else begin
            run <= 1'b1;
            rc  <= cur_rc + 1'b1;
          end
        end else begin
          ph  <= cur_ph + 1'b1;
          rc  <= cur_rc;
          run <= 1'b1;
        end
      end
    end
  end

  AST_REPEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (rc < seq.reps)); // R3
  AST_ZERO_REPEAT_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (seq.reps == '0 && !line_start) |=> (vclk == $past(pat.rest))); // R3
endmodule

// File: rtl/vfield_seq.sv
module vfield_seq
  import vfs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hd_i,
  input  logic              vd_i,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_wr_addr,
  input  logic [DATA_W-1:0] cfg_wr_data,
  output logic [NOUT-1:0]   vclk_o,
  output logic [IDX_W-1:0]  seq_idx_o,
  output logic              field_done_o
);
  pat_cfg_t          cur_pat;
  seq_cfg_t          cur_seq;
  logic [PIX_W-1:0]  next_bnd, pix;
  logic [SLOT_W-1:0] slot_count, slot;
  logic [REG_W-1:0]  region;
  logic              line_start;

  vfs_cfg_bank u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
    .wr_data(cfg_wr_data), .commit(vd_i), .slot(slot), .region(region),
    .cur_pat(cur_pat), .cur_seq(cur_seq), .cur_seq_idx(seq_idx_o),
    .next_bnd(next_bnd), .slot_count(slot_count)
  );

  vfs_line_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .hd(hd_i), .vd(vd_i), .next_bnd(next_bnd),
    .slot_count(slot_count), .pix(pix), .line_start(line_start),
    .region(region), .slot(slot), .field_done(field_done_o)
  );

  vfs_pattern_walker u_walk (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .pix(pix),
    .pat(cur_pat), .seq(cur_seq), .vclk(vclk_o)
  );
endmodule

// File: tb/vfield_seq_tb.sv
module vfield_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_PIX   = 40;
  localparam int NLINES     = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hd_i = 1'b0, vd_i = 1'b0, cfg_wr_en = 1'b0;
  logic [9:0]  cfg_wr_addr = '0;
  logic [15:0] cfg_wr_data = '0;
  logic [5:0]  vclk_o;
  logic [3:0]  seq_idx_o;
  logic        field_done_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vfield_seq dut_i (
    .clk(clk), .rst_n(rst_n), .hd_i(hd_i), .vd_i(vd_i), .cfg_wr_en(cfg_wr_en),
    .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data), .vclk_o(vclk_o),
    .seq_idx_o(seq_idx_o), .field_done_o(field_done_o)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  string ctx = "";

  // shadow and active models
  int sh_len[10], ac_len[10], sh_ta[10][6], ac_ta[10][6], sh_tb[10][6], ac_tb[10][6];
  logic [5:0] sh_rest[10], ac_rest[10];
  int sh_spat[10], ac_spat[10], sh_sst[10], ac_sst[10], sh_srep[10], ac_srep[10];
  int sh_rseq[6][7], ac_rseq[6][7], sh_bnd[6][6], ac_bnd[6][6];
  int sh_cnt, ac_cnt, sh_slot[7], ac_slot[7];
  int m_slot = 0, m_line = 0, m_region = 0;
  bit m_started = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic commit_model();
    ac_len = sh_len; ac_ta = sh_ta; ac_tb = sh_tb; ac_rest = sh_rest;
    ac_spat = sh_spat; ac_sst = sh_sst; ac_srep = sh_srep;
    ac_rseq = sh_rseq; ac_bnd = sh_bnd; ac_cnt = sh_cnt; ac_slot = sh_slot;
  endtask

  function automatic int cur_fld();
    int f = ac_slot[m_slot];
    return (f >= 6) ? 0 : f;
  endfunction
  function automatic int cur_seq();
    int s = ac_rseq[cur_fld()][m_region];
    return (s >= 10) ? 0 : s;
  endfunction
  function automatic int cur_pat();
    int p = ac_spat[cur_seq()];
    return (p >= 10) ? 0 : p;
  endfunction

  function automatic logic [5:0] exp_vclk(input int k);
    int s = cur_seq();
    int p = cur_pat();
    int len = ac_len[p] + 1;
    logic [5:0] v = ac_rest[p];
    if (ac_srep[s] != 0 && k >= ac_sst[s] && k < ac_sst[s] + ac_srep[s] * len) begin
      int q = (k - ac_sst[s]) % len;
      for (int j = 0; j < 6; j++)
        v[j] = ac_rest[p][j] ^ (q >= ac_ta[p][j]) ^ (q >= ac_tb[p][j]);
    end
    return v;
  endfunction

  function automatic string line_tag();
    if (ctx != "") return ctx;
    if (ac_spat[cur_seq()] >= 10) return "R9";
    if (ac_srep[cur_seq()] == 0) return "R3";
    return "R2";
  endfunction

  task automatic cfg_wr(input logic [9:0] a, input int d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = 16'(d);
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic set_pat(input int p, input bit force_short);
    sh_len[p]  = force_short ? 0 : $urandom_range(7, 0);
    sh_rest[p] = 6'($urandom());
    cfg_wr({2'b00, 4'(p), 4'd0}, sh_len[p]);
    cfg_wr({2'b00, 4'(p), 4'd1}, sh_rest[p]);
    for (int j = 0; j < 6; j++) begin
      sh_ta[p][j] = $urandom_range(sh_len[p] + 1, 0);
      sh_tb[p][j] = $urandom_range(sh_len[p] + 1, 0);
      cfg_wr({2'b00, 4'(p), 4'(j + 2)}, sh_ta[p][j]);
      cfg_wr({2'b00, 4'(p), 4'(j + 8)}, sh_tb[p][j]);
    end
  endtask

  task automatic set_seq(input int s, input int p, input int st, input int r);
    sh_spat[s] = p; sh_sst[s] = st; sh_srep[s] = r;
    cfg_wr({2'b01, 6'(s), 2'd0}, p);
    cfg_wr({2'b01, 6'(s), 2'd1}, st);
    cfg_wr({2'b01, 6'(s), 2'd2}, r);
  endtask

  task automatic set_fld(input int f, input int r, input int s);
    sh_rseq[f][r] = s;
    cfg_wr({2'b10, 4'(f), 4'(r)}, s);
  endtask

  task automatic set_bnd(input int f, input int r, input int b);
    sh_bnd[f][r] = b;
    cfg_wr({2'b10, 4'(f), 4'(r + 8)}, b);
  endtask

  task automatic start_field(input bit with_hd, input bit wen, input logic [9:0] a, input int d);
    bit exp_done;
    @(negedge clk);
    vd_i = 1'b1; hd_i = with_hd;
    if (wen) begin cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = 16'(d); end
    @(negedge clk);
    vd_i = 1'b0; hd_i = 1'b0; cfg_wr_en = 1'b0;
    exp_done = m_started;
    if (!m_started) m_slot = 0;
    else if (m_slot + 1 >= ((ac_cnt == 0) ? 1 : ac_cnt)) m_slot = 0;
    else m_slot++;
    m_started = 1;
    commit_model();
    m_line = 0; m_region = 0;
    check(field_done_o == exp_done, "R6", "field_done at strobe", field_done_o, exp_done);
    check(seq_idx_o == 4'(cur_seq()), with_hd ? "R8" : "R5", "seq_idx at field start", seq_idx_o, cur_seq());
  endtask

  task automatic run_line();
    for (int k = 0; k < LINE_PIX; k++) begin
      logic [5:0] e;
      @(negedge clk);
      e = exp_vclk(k);
      if (k == 0) check(field_done_o == 1'b0, "R6", "field_done one cycle", field_done_o, 0);
      check(vclk_o == e, line_tag(), $sformatf("vclk line %0d pix %0d", m_line, k), vclk_o, e);
    end
  endtask

  task automatic next_line();
    @(negedge clk);
    hd_i = 1'b1;
    @(negedge clk);
    hd_i = 1'b0;
    m_line++;
    if (m_region < 6 && m_line == ac_bnd[cur_fld()][m_region]) m_region++;
    check(seq_idx_o == 4'(cur_seq()), "R4", $sformatf("seq_idx line %0d", m_line), seq_idx_o, cur_seq());
  endtask

  task automatic play_lines();
    run_line();
    for (int ln = 1; ln < NLINES; ln++) begin
      next_line();
      run_line();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int p = 0; p < 10; p++) begin
      sh_len[p] = 0; sh_rest[p] = '0;
      for (int j = 0; j < 6; j++) begin sh_ta[p][j] = 0; sh_tb[p][j] = 0; end
    end
    for (int s = 0; s < 10; s++) begin sh_spat[s] = 0; sh_sst[s] = 0; sh_srep[s] = 0; end
    for (int f = 0; f < 6; f++) begin
      for (int r = 0; r < 7; r++) sh_rseq[f][r] = 0;
      for (int r = 0; r < 6; r++) sh_bnd[f][r] = 0;
    end
    sh_cnt = 0;
    for (int i = 0; i < 7; i++) sh_slot[i] = 0;
    commit_model();

    repeat (3) @(negedge clk);
    check(vclk_o == 6'd0, "R1", "vclk in reset", vclk_o, 0);
    check(seq_idx_o == 4'd0, "R1", "seq_idx in reset", seq_idx_o, 0);
    check(field_done_o == 1'b0, "R1", "field_done in reset", field_done_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(vclk_o == 6'd0 && field_done_o == 1'b0, "R1", "outputs after reset", vclk_o, 0);

    // directed field layout
    set_fld(0, 0, 0); set_fld(0, 1, 1); set_fld(0, 2, 2);
    set_bnd(0, 0, 3); set_bnd(0, 1, 5);
    for (int r = 2; r < 6; r++) set_bnd(0, r, 4095);
    set_fld(1, 0, 3); set_fld(1, 1, 4);
    set_bnd(1, 0, 2);
    for (int r = 1; r < 6; r++) set_bnd(1, r, 4095);
    set_fld(2, 0, 1);
    for (int r = 0; r < 6; r++) set_bnd(2, r, 4095);
    sh_cnt = 3; cfg_wr({2'b11, 4'd0, 4'd0}, 3);
    sh_slot[0] = 1; cfg_wr({2'b11, 4'd0, 4'd1}, 1);
    sh_slot[1] = 0; cfg_wr({2'b11, 4'd0, 4'd2}, 0);
    sh_slot[2] = 1; cfg_wr({2'b11, 4'd0, 4'd3}, 1);
    set_seq(4, 12, 5, 2);   // out-of-range pattern index -> pattern 0 (R9)

    for (int rnd = 0; rnd < 3; rnd++) begin
      for (int p = 0; p < 4; p++) set_pat(p, rnd == 0 && p == 2);
      for (int s = 0; s < 3; s++) set_seq(s, s, $urandom_range(20, 0), $urandom_range(3, 1));
      set_seq(3, 3, $urandom_range(20, 0), 0);
      if (rnd == 0) begin
        for (int i = 0; i < 4; i++) begin
          @(negedge clk);
          check(vclk_o == 6'd0 && seq_idx_o == 4'd0, "R7", "writes not active before strobe", vclk_o, 0);
        end
      end else begin
        ctx = "R7";
        next_line();
        run_line();
        ctx = "";
      end
      if (rnd == 1) ctx = "R8";
      start_field(rnd == 1, rnd == 2, {2'b01, 6'd1, 2'd1}, 33);
      if (rnd == 2) begin sh_sst[1] = 33; ctx = "R7"; end
      run_line();
      ctx = (rnd == 2) ? "R7" : "";
      for (int ln = 1; ln < NLINES; ln++) begin
        next_line();
        run_line();
      end
      ctx = "";
      for (int fl = 1; fl < 4; fl++) begin
        start_field(1'b0, 1'b0, '0, 0);
        play_lines();
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule